// File: doc/BRIEF.md
# Exception Vector Window Remapper

This block sits between a processor's address bus and its memory decoders. The lowest 64 bytes of the address space hold 32 bytes of exception vectors and 32 bytes of branch constants. Accesses to these bytes are sent to one of four backing memories, and the choice follows a two-bit remap mode register. The mode options are the boot ROM, the bottom of flash, the bottom of on-chip static RAM, and external bank 0. Every other address keeps its fixed location. After any reset the block is in boot mode, so the boot ROM serves the vectors. The boot ROM lives at the top of the on-chip space, so its position does not depend on how much flash a part has.

A separate mirror bit swaps external banks 0 and 1. It keeps the offset within the bank. Boot code sets this bit when it starts from external memory wired to the second chip select. The swap is applied after the vector redirection. In external mode with the mirror set, the vectors therefore come from the physical bank 1.

The path from address to translated address and region code is purely combinational. The mode and mirror registers are the only state. Software loads both registers together through one write strobe, and the new setting governs the very next access.

Top module: `vector_remap_decoder`

## Requirements
- R1: While reset is asserted and after it is released, the mode is boot (code 00) and the mirror is off, until the first write.
- R2: An address is inside the vector window when all bits above bit 5 are zero. Address 0x3F is inside the window and 0x40 is outside it.
- R3: In boot mode (code 00), a window address maps to ROM_BASE plus the low six address bits.
- R4: In flash mode (code 01), a window address passes through unchanged.
- R5: In RAM mode (code 10), a window address maps to SRAM_BASE plus the low six address bits.
- R6: In external mode (code 11), a window address maps to EXT0_BASE plus the low six address bits.
- R7: An address outside the window leaves unchanged in every mode, unless R8 swaps it.
- R8: With the mirror bit set, an address in bank 0 (EXT0_BASE, size EXT_SIZE) maps to EXT1_BASE plus the same offset, and the reverse also holds. The swap is applied after the window redirection. With the mirror bit clear, bank addresses pass through unchanged.
- R9: The region code describes the translated address: 1 flash, 2 static RAM, 3 boot ROM, 4 external bank 0, 5 external bank 1, and 0 for none of these.
- R10: A clock edge with wr_en_i high loads wr_mode_i and wr_mirror_i together. With wr_en_i low, the settings hold and the write inputs have no effect.
- R11: At most one region range matches any translated address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the mode and mirror registers |
| wr_mode_i | input | 2 | New remap mode (00 boot, 01 flash, 10 RAM, 11 external) |
| wr_mirror_i | input | 1 | New value of the bank mirror bit |
| addr_i | input | AW | Incoming bus address |
| addr_o | output | AW | Translated address |
| region_o | output | 3 | Region code of the translated address |

## Verification
The assertions assume that the region ranges given by the parameters do not overlap. They also assume that external bank 0 is the same size as bank 1, so that a swapped offset lands inside the other bank. The base-and-offset checks further assume that the ROM, SRAM and EXT0 bases are aligned to 64 bytes. The bench uses only the default parameters, which meet all of these conditions. It changes the mode and mirror only through the write strobe, away from the clock edge. Each address is held steady for a full cycle before it is sampled, so the clocked checks see settled combinational outputs.

// File: rtl/vremap_pkg.sv
package vremap_pkg;

  typedef enum logic [1:0] {
    MODE_BOOT  = 2'b00,
    MODE_FLASH = 2'b01,
    MODE_RAM   = 2'b10,
    MODE_EXT   = 2'b11
  } remap_mode_e;

  typedef enum logic [2:0] {
    RGN_NONE  = 3'd0,
    RGN_FLASH = 3'd1,
    RGN_SRAM  = 3'd2,
    RGN_ROM   = 3'd3,
    RGN_EXT0  = 3'd4,
    RGN_EXT1  = 3'd5
  } region_e;

  localparam int NUM_RGN = 5;

endpackage

// File: rtl/remap_ctrl_regs.sv
module remap_ctrl_regs
  import vremap_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en_i,
  input  logic [1:0]  wr_mode_i,
  input  logic        wr_mirror_i,
  output remap_mode_e mode_o,
  output logic        mirror_o
);

  remap_mode_e mode_q;
  logic        mirror_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_BOOT;
      mirror_q <= 1'b0;
    end else if (wr_en_i) begin
      mode_q   <= remap_mode_e'(wr_mode_i);
      mirror_q <= wr_mirror_i;
    end
  end

  assign mode_o   = mode_q;
  assign mirror_o = mirror_q;

  // R1: the first edge after reset release still sees boot mode, mirror off
  a_r1_reset_boot: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mode_q == MODE_BOOT) && !mirror_q);

  // R10: strobe loads both fields
  a_r10_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (mode_q == remap_mode_e'($past(wr_mode_i))) && (mirror_q == $past(wr_mirror_i)));

  // R10: no strobe, no change
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(mode_q) && $stable(mirror_q));

endmodule

// File: rtl/vec_window_sel.sv
module vec_window_sel
  import vremap_pkg::*;
#(
  parameter int          AW        = 32,
  parameter int          WIN_BITS  = 6,
  parameter logic [AW-1:0] ROM_BASE  = 32'h7FFF_E000,
  parameter logic [AW-1:0] SRAM_BASE = 32'h4000_0000,
  parameter logic [AW-1:0] EXT0_BASE = 32'hA000_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  remap_mode_e   mode_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o,
  output logic          win_hit_o
);

  localparam int HI_BITS = AW - WIN_BITS;

  function automatic logic [AW-1:0] rebase(input logic [AW-1:0] base,
                                           input logic [AW-1:0] a);
    return base + {{HI_BITS{1'b0}}, a[WIN_BITS-1:0]};
  endfunction

  logic win_hit;
  assign win_hit   = (addr_i[AW-1:WIN_BITS] == '0);
  assign win_hit_o = win_hit;

  always_comb begin
    addr_o = addr_i;
    if (win_hit) begin
      unique case (mode_i)
        MODE_BOOT:  addr_o = rebase(ROM_BASE, addr_i);
        MODE_FLASH: addr_o = addr_i;
        MODE_RAM:   addr_o = rebase(SRAM_BASE, addr_i);
        MODE_EXT:   addr_o = rebase(EXT0_BASE, addr_i);
        default:    addr_o = addr_i;
      endcase
    end
  end

  // R7: outside the window nothing is changed here
  a_r7_outside_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !win_hit |-> addr_o == addr_i);

  // R5: RAM mode lands in the SRAM's first 64 bytes
  a_r5_ram_base: assert property (@(posedge clk) disable iff (!rst_n)
    (win_hit && mode_i == MODE_RAM) |-> addr_o[AW-1:WIN_BITS] == SRAM_BASE[AW-1:WIN_BITS]);

  // R3: boot mode keeps the low offset bits
  a_r3_boot_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (win_hit && mode_i == MODE_BOOT) |-> addr_o[WIN_BITS-1:0] == addr_i[WIN_BITS-1:0]);

endmodule

// File: rtl/bank_mirror.sv
module bank_mirror #(
  parameter int            AW        = 32,
  parameter logic [AW-1:0] EXT0_BASE = 32'hA000_0000,
  parameter logic [AW-1:0] EXT1_BASE = 32'hA100_0000,
  parameter logic [AW-1:0] EXT_SIZE  = 32'h0100_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mirror_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o,
  output logic          swapped_o
);

  function automatic logic inside_bank(input logic [AW-1:0] a,
                                       input logic [AW-1:0] base);
    return (a >= base) && ((a - base) < EXT_SIZE);
  endfunction

  logic in_b0, in_b1;
  assign in_b0 = inside_bank(addr_i, EXT0_BASE);
  assign in_b1 = inside_bank(addr_i, EXT1_BASE);

  always_comb begin
    addr_o = addr_i;
    if (mirror_i && in_b0)      addr_o = addr_i - EXT0_BASE + EXT1_BASE;
    else if (mirror_i && in_b1) addr_o = addr_i - EXT1_BASE + EXT0_BASE;
  end

  assign swapped_o = mirror_i && (in_b0 || in_b1);

  // R8: mirror off is transparent
  a_r8_off_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !mirror_i |-> addr_o == addr_i);

  // R8: a bank-0 address ends up inside bank 1
  a_r8_swap_b0: assert property (@(posedge clk) disable iff (!rst_n)
    (mirror_i && in_b0) |-> inside_bank(addr_o, EXT1_BASE));

endmodule

// File: rtl/region_decode.sv
module region_decode
  import vremap_pkg::*;
#(
  parameter int            AW         = 32,
  parameter logic [AW-1:0] FLASH_BASE = 32'h0000_0000,
  parameter logic [AW-1:0] FLASH_SIZE = 32'h0008_0000,
  parameter logic [AW-1:0] SRAM_BASE  = 32'h4000_0000,
  parameter logic [AW-1:0] SRAM_SIZE  = 32'h0001_0000,
  parameter logic [AW-1:0] ROM_BASE   = 32'h7FFF_E000,
  parameter logic [AW-1:0] ROM_SIZE   = 32'h0000_2000,
  parameter logic [AW-1:0] EXT0_BASE  = 32'hA000_0000,
  parameter logic [AW-1:0] EXT1_BASE  = 32'hA100_0000,
  parameter logic [AW-1:0] EXT_SIZE   = 32'h0100_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_i,
  output region_e       region_o
);

  localparam logic [NUM_RGN*AW-1:0] BASES =
    {EXT1_BASE, EXT0_BASE, ROM_BASE, SRAM_BASE, FLASH_BASE};
  localparam logic [NUM_RGN*AW-1:0] SIZES =
    {EXT_SIZE, EXT_SIZE, ROM_SIZE, SRAM_SIZE, FLASH_SIZE};

  logic [NUM_RGN-1:0] hit;

  for (genvar g = 0; g < NUM_RGN; g++) begin : g_rng
    localparam logic [AW-1:0] B = BASES[g*AW +: AW];
    localparam logic [AW-1:0] S = SIZES[g*AW +: AW];
    assign hit[g] = (addr_i >= B) && ((addr_i - B) < S);
  end

  always_comb begin
    region_o = RGN_NONE;
    for (int i = NUM_RGN - 1; i >= 0; i--) begin
      if (hit[i]) region_o = region_e'(3'(i + 1));
    end
  end

  // R11: ranges never overlap
  a_r11_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));

  // R9: no hit means region none
  a_r9_none: assert property (@(posedge clk) disable iff (!rst_n)
    (hit == '0) |-> region_o == RGN_NONE);

endmodule

// File: rtl/vector_remap_decoder.sv
module vector_remap_decoder
  import vremap_pkg::*;
#(
  parameter int            AW         = 32,
  parameter int            WIN_BITS   = 6,
  parameter logic [AW-1:0] FLASH_BASE = 32'h0000_0000,
  parameter logic [AW-1:0] FLASH_SIZE = 32'h0008_0000,
  parameter logic [AW-1:0] SRAM_BASE  = 32'h4000_0000,
  parameter logic [AW-1:0] SRAM_SIZE  = 32'h0001_0000,
  parameter logic [AW-1:0] ROM_BASE   = 32'h7FFF_E000,
  parameter logic [AW-1:0] ROM_SIZE   = 32'h0000_2000,
  parameter logic [AW-1:0] EXT0_BASE  = 32'hA000_0000,
  parameter logic [AW-1:0] EXT1_BASE  = 32'hA100_0000,
  parameter logic [AW-1:0] EXT_SIZE   = 32'h0100_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_mode_i,
  input  logic          wr_mirror_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o,
  output logic [2:0]    region_o
);

  remap_mode_e   mode;
  logic          mirror;
  logic [AW-1:0] win_addr;
  logic          win_hit;
  logic          swapped;
  region_e       region;

  remap_ctrl_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (wr_en_i),
    .wr_mode_i  (wr_mode_i),
    .wr_mirror_i(wr_mirror_i),
    .mode_o     (mode),
    .mirror_o   (mirror)
  );

  vec_window_sel #(
    .AW(AW), .WIN_BITS(WIN_BITS),
    .ROM_BASE(ROM_BASE), .SRAM_BASE(SRAM_BASE), .EXT0_BASE(EXT0_BASE)
  ) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_i   (mode),
    .addr_i   (addr_i),
    .addr_o   (win_addr),
    .win_hit_o(win_hit)
  );

  bank_mirror #(
    .AW(AW), .EXT0_BASE(EXT0_BASE), .EXT1_BASE(EXT1_BASE), .EXT_SIZE(EXT_SIZE)
  ) u_mirror (
    .clk      (clk),
    .rst_n    (rst_n),
    .mirror_i (mirror),
    .addr_i   (win_addr),
    .addr_o   (addr_o),
    .swapped_o(swapped)
  );

  region_decode #(
    .AW(AW),
    .FLASH_BASE(FLASH_BASE), .FLASH_SIZE(FLASH_SIZE),
    .SRAM_BASE(SRAM_BASE),   .SRAM_SIZE(SRAM_SIZE),
    .ROM_BASE(ROM_BASE),     .ROM_SIZE(ROM_SIZE),
    .EXT0_BASE(EXT0_BASE),   .EXT1_BASE(EXT1_BASE), .EXT_SIZE(EXT_SIZE)
  ) u_rgn (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_i  (addr_o),
    .region_o(region)
  );

  assign region_o = region;

  // R4: flash mode with no swap leaves the address alone
  a_r4_flash_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_FLASH && !swapped) |-> addr_o == addr_i);

  // R2/R7: outside the window and with no swap, the output equals the input
  a_r2_edge_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_hit && !swapped) |-> addr_o == addr_i);

endmodule

// File: tb/tb_vector_remap_decoder.sv
module tb_vector_remap_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_mode_i = 2'b00;
  logic        wr_mirror_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic [31:0] addr_o;
  logic [2:0]  region_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vector_remap_decoder dut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_mode_i(wr_mode_i),
    .wr_mirror_i(wr_mirror_i), .addr_i(addr_i), .addr_o(addr_o), .region_o(region_o)
  );

  typedef struct packed {
    logic [1:0]  m;
    logic        mir;
    logic [31:0] a;
    logic [31:0] ea;
    logic [2:0]  er;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VT [NV] = '{
    '{2'b00, 1'b0, 32'h0000_0000, 32'h7FFF_E000, 3'd3},
    '{2'b00, 1'b0, 32'h0000_003F, 32'h7FFF_E03F, 3'd3},
    '{2'b00, 1'b0, 32'h0000_0040, 32'h0000_0040, 3'd1},
    '{2'b01, 1'b0, 32'h0000_001C, 32'h0000_001C, 3'd1},
    '{2'b01, 1'b0, 32'h0000_003F, 32'h0000_003F, 3'd1},
    '{2'b10, 1'b0, 32'h0000_0004, 32'h4000_0004, 3'd2},
    '{2'b10, 1'b0, 32'h0000_003F, 32'h4000_003F, 3'd2},
    '{2'b10, 1'b0, 32'h0000_0040, 32'h0000_0040, 3'd1},
    '{2'b11, 1'b0, 32'h0000_0008, 32'hA000_0008, 3'd4},
    '{2'b11, 1'b1, 32'h0000_0008, 32'hA100_0008, 3'd5},
    '{2'b11, 1'b1, 32'h0000_0040, 32'h0000_0040, 3'd1},
    '{2'b01, 1'b1, 32'hA000_0100, 32'hA100_0100, 3'd5},
    '{2'b01, 1'b1, 32'hA100_0010, 32'hA000_0010, 3'd4},
    '{2'b10, 1'b1, 32'h4000_0200, 32'h4000_0200, 3'd2},
    '{2'b00, 1'b1, 32'h0000_0010, 32'h7FFF_E010, 3'd3},
    '{2'b11, 1'b0, 32'h7FFF_E004, 32'h7FFF_E004, 3'd3},
    '{2'b10, 1'b0, 32'h1000_0000, 32'h1000_0000, 3'd0},
    '{2'b11, 1'b0, 32'hA0FF_FFFF, 32'hA0FF_FFFF, 3'd4},
    '{2'b11, 1'b1, 32'hA0FF_FFFF, 32'hA1FF_FFFF, 3'd5},
    '{2'b01, 1'b0, 32'h0007_FFFF, 32'h0007_FFFF, 3'd1},
    '{2'b01, 1'b0, 32'h0008_0000, 32'h0008_0000, 3'd0},
    '{2'b00, 1'b0, 32'hA100_0000, 32'hA100_0000, 3'd5}
  };

  function automatic string tag_of(input logic [1:0] m, input logic mir,
                                   input logic [31:0] a);
    logic bank;
    bank = (a >= 32'hA000_0000) && (a < 32'hA200_0000);
    if (a < 32'h40) begin
      case (m)
        2'b00:   return "R3";
        2'b01:   return "R4";
        2'b10:   return "R5";
        default: return mir ? "R8" : "R6";
      endcase
    end
    if (mir && bank) return "R8";
    return "R7";
  endfunction

  task automatic write_cfg(input logic [1:0] m, input logic mir);
    @(negedge clk);
    wr_en_i = 1'b1; wr_mode_i = m; wr_mirror_i = mir;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic check(input string req, input logic [31:0] a,
                       input logic [31:0] ea, input logic [2:0] er);
    addr_i = a;
    @(negedge clk);
    checks++;
    if (addr_o !== ea || region_o !== er) begin
      failures++;
      $display("FAIL %s addr=%h: got addr=%h region=%0d, expected addr=%h region=%0d",
               req, a, addr_o, region_o, ea, er);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state seen while reset is held, then after release
    check("R1", 32'h0000_0020, 32'h7FFF_E020, 3'd3);
    rst_n = 1'b1;
    check("R1", 32'h0000_0000, 32'h7FFF_E000, 3'd3);
    check("R1", 32'hA000_0000, 32'hA000_0000, 3'd4);

    // table walk, R2..R9
    for (int i = 0; i < NV; i++) begin
      write_cfg(VT[i].m, VT[i].mir);
      check(tag_of(VT[i].m, VT[i].mir, VT[i].a), VT[i].a, VT[i].ea, VT[i].er);
    end

    // R2: window edges in RAM mode
    write_cfg(2'b10, 1'b0);
    check("R2", 32'h0000_003F, 32'h4000_003F, 3'd2);
    check("R2", 32'h0000_0040, 32'h0000_0040, 3'd1);
    check("R2", 32'h8000_0000, 32'h8000_0000, 3'd0);

    // R10: inputs change without strobe, setting must hold (RAM, no mirror)
    @(negedge clk);
    wr_mode_i = 2'b11; wr_mirror_i = 1'b1;
    repeat (2) @(negedge clk);
    check("R10", 32'h0000_0008, 32'h4000_0008, 3'd2);
    check("R10", 32'hA000_0004, 32'hA000_0004, 3'd4);

    // R10: strobe takes effect at once on the next access
    write_cfg(2'b11, 1'b1);
    check("R10", 32'h0000_0000, 32'hA100_0000, 3'd5);

    // R9: region codes across several translated spaces
    write_cfg(2'b01, 1'b0);
    check("R9", 32'h4000_FFFF, 32'h4000_FFFF, 3'd2);
    check("R9", 32'h4001_0000, 32'h4001_0000, 3'd0);
    check("R9", 32'h7FFF_FFFF, 32'h7FFF_FFFF, 3'd3);

    // R1: a second reset returns to boot mode and clears the mirror
    write_cfg(2'b10, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1", 32'h0000_0004, 32'h7FFF_E004, 3'd3);
    check("R1", 32'hA100_0004, 32'hA100_0004, 3'd5);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule